// File: doc/BRIEF.md
# Posted Register Write Pending Tracker

This block is the bus-side register front end of a peripheral whose working registers are clocked by a separate, slower functional clock. Ten registers can take posted writes. In posted mode a bus write to one of them completes on the bus at once. The value then crosses into the functional domain through a toggle-and-acknowledge handshake. For each posted register a pending bit stays set from the bus write until the acknowledge has come back through a synchroniser. Software polls a write-pending status word before it touches a register again. While a register's bit is still set, a new write to that register is dropped, and a read of it returns the value that was last applied.

When posted mode is off, the bus write still goes out, but `bus_ready` stays low until the functional domain has applied the value, and the pending word reads zero. An interface-control register holds the posted-mode switch and the soft-reset trigger. A soft reset returns the functional registers to their defaults and clears all pending state. Completion of the soft reset is reported through a system-status bit.

Top module: `posted_wr_tracker`

## Requirements
- R1: After hardware reset the interface-control word (offset 0x40) reads 0x4, meaning posted mode is on in bit 2. The write-pending word (offset 0x34) reads 0, system-status (offset 0x14) bit 0 reads 1, and every functional register is 0.
- R2: The posted registers sit at these offsets, with the listed write-pending bit: 0x24 bit 0, 0x28 bit 1, 0x2C bit 2, 0x30 bit 3, 0x38 bit 4, 0x48 bit 5, 0x4C bit 6, 0x50 bit 7, 0x54 bit 8, 0x58 bit 9. In posted mode a write keeps `bus_ready` high, and the register's pending bit reads 1 in the cycle after the write. The bit later clears, and the written value then appears on that register's slice of `fn_regs`.
- R3: A write to a posted register whose pending bit is still 1 is dropped. The functional register keeps the earlier value.
- R4: While a register's pending bit is 1, a bus read of that register returns the previously applied value. Once the bit is clear, the read returns the new value.
- R5: Pending bits are independent. Writes to two different posted registers in close succession are both accepted and both applied.
- R6: Writing 0 to bit 2 of interface control selects non-posted mode. In this mode the pending word reads 0. After a posted-register write, `bus_ready` is low from the next cycle until the value has been applied, and it then returns high.
- R7: Writing interface control with bit 1 set (for example 0x06) starts a soft reset. System-status bit 0 reads 0 from the next cycle until the reset is complete, and then reads 1 again. Posted-register writes issued during the reset are dropped. Afterwards every functional register is 0, the pending word is 0, and posted mode is on.
- R8: During a soft reset, `fn_soft_rst` is held high for at least SRST_HOLD (default 2) functional clocks.
- R9: Reads of unmapped offsets return 0. Bus writes to the status words (0x34, 0x14) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| fn_clk | input | 1 | Functional clock |
| fn_rst_n | input | 1 | Functional-domain asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe; the write is taken on a clock edge where `bus_ready` is high |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from `bus_addr` |
| bus_ready | output | 1 | Low while a non-posted write is in flight |
| fn_regs | output | 10*DW | Applied functional-domain values, register i at slice i |
| fn_soft_rst | output | 1 | Soft-reset level in the functional domain |

## Verification
The bench goes after the collision case: a second write lands on a register whose first write is still pending. A design that failed to drop it would apply the second value, or hand the functional side data that changes under the handshake. It also checks stale readback during the pending window; a design that returned the new value too early would not show the lag software depends on. The non-posted stall is checked, because a design that kept `bus_ready` high would let back-to-back accesses overtake the crossing. The soft reset is checked for status-bit timing, for dropped writes during the reset, and for the reset level staying high long enough; a short or missing reset would leave old functional values or pending bits behind.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
   localparam int NREG = 10;
   localparam int AW   = 8;
   typedef logic [AW-1:0] addr_t;

   // offsets of the posted registers; index = write-pending bit
   localparam addr_t REG_OFF [NREG] = '{8'h24, 8'h28, 8'h2C, 8'h30, 8'h38,
                                        8'h48, 8'h4C, 8'h50, 8'h54, 8'h58};
   localparam addr_t OFF_SYSSTAT = 8'h14;
   localparam addr_t OFF_WPEND   = 8'h34;
   localparam addr_t OFF_IFC     = 8'h40;
   localparam int    IFC_SRST_BIT = 1;
   localparam int    IFC_POST_BIT = 2;

   typedef enum logic [1:0] {SR_IDLE, SR_ASSERT, SR_RELEASE} sr_state_e;
endpackage

// File: rtl/wpt_sync.sv
module wpt_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wpt_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/wpt_bus_chan.sv
module wpt_bus_chan #(
   parameter int          DW      = 32,
   parameter int          STAGES  = 2,
   parameter logic [DW-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_hit,
   input  logic [DW-1:0] wdata,
   input  logic          clr,
   input  logic          sr_busy,
   input  logic          ack_tgl_f,
   output logic          req_tgl,
   output logic [DW-1:0] hold_q,
   output logic [DW-1:0] rdata,
   output logic          pend
);
   logic          ack_s;
   logic          inflight;
   logic          take;
   logic [DW-1:0] appl_q;

   wpt_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(ack_tgl_f), .q(ack_s));

   assign inflight = req_tgl ^ ack_s;
   assign pend     = inflight & ~sr_busy;
   assign take     = wr_hit & ~inflight & ~sr_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_tgl <= 1'b0;
         hold_q  <= RST_VAL;
         appl_q  <= RST_VAL;
      end else if (clr) begin
         req_tgl <= 1'b0;
         hold_q  <= RST_VAL;
         appl_q  <= RST_VAL;
      end else begin
         if (take) begin
            req_tgl <= ~req_tgl;
            hold_q  <= wdata;
         end
         if (!inflight) appl_q <= hold_q;
      end
   end

   // while in flight, software sees the previously applied value
   assign rdata = inflight ? appl_q : hold_q;

   // R2: a pending bit only rises because a write was taken
   a_r2_pend_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(take));

   // R3: data crossing domains stays frozen while its handshake runs
   a_r3_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (inflight && !clr) |=> $stable(hold_q));
endmodule

// File: rtl/wpt_fn_chan.sv
module wpt_fn_chan #(
   parameter int          DW      = 32,
   parameter int          STAGES  = 2,
   parameter logic [DW-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          srst,
   input  logic          req_tgl_b,
   input  logic [DW-1:0] hold_b,
   output logic          ack_tgl,
   output logic [DW-1:0] q
);
   logic req_s;

   wpt_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req_tgl_b), .q(req_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_tgl <= 1'b0;
         q       <= RST_VAL;
      end else if (srst) begin
         ack_tgl <= 1'b0;
         q       <= RST_VAL;
      end else if (req_s != ack_tgl) begin
         ack_tgl <= req_s;
         q       <= hold_b;
      end
   end

   // R2: the applied value changes only on a new request or a soft reset
   a_r2_apply_on_req: assert property (@(posedge clk) disable iff (!rst_n)
      (req_s == ack_tgl && !srst) |=> $stable(q));
endmodule

// File: rtl/wpt_srst_ctl.sv
module wpt_srst_ctl import wpt_pkg::*; #(
   parameter int STAGES = 2,
   parameter int HOLD   = 2
) (
   input  logic bus_clk,
   input  logic bus_rst_n,
   input  logic fn_clk,
   input  logic fn_rst_n,
   input  logic start,
   output logic busy,
   output logic fn_srst
);
   localparam int CW = $clog2(HOLD + 1);

   if (HOLD < 2) begin : g_bad_hold
      $error("wpt_srst_ctl: HOLD must be at least 2");
   end

   sr_state_e state_q;
   logic      req_b;
   logic      done_f;
   logic      done_s;
   logic [CW-1:0] cnt_q;

   assign req_b = (state_q == SR_ASSERT);
   assign busy  = (state_q != SR_IDLE);

   wpt_sync #(.W(1), .STAGES(STAGES)) u_done_sync (
      .clk(bus_clk), .rst_n(bus_rst_n), .d(done_f), .q(done_s));
   wpt_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
      .clk(fn_clk), .rst_n(fn_rst_n), .d(req_b), .q(fn_srst));

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) state_q <= SR_IDLE;
      else begin
         unique case (state_q)
            SR_IDLE:    if (start)   state_q <= SR_ASSERT;
            SR_ASSERT:  if (done_s)  state_q <= SR_RELEASE;
            SR_RELEASE: if (!done_s) state_q <= SR_IDLE;
            default:                 state_q <= SR_IDLE;
         endcase
      end
   end

   always_ff @(posedge fn_clk or negedge fn_rst_n) begin
      if (!fn_rst_n) begin
         cnt_q  <= '0;
         done_f <= 1'b0;
      end else if (!fn_srst) begin
         cnt_q  <= '0;
         done_f <= 1'b0;
      end else begin
         if (cnt_q != CW'(HOLD)) cnt_q <= cnt_q + 1'b1;
         done_f <= (cnt_q == CW'(HOLD));
      end
   end

   // R7: reset-done drops only because a soft reset was requested
   a_r7_busy_from_start: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      $rose(busy) |-> $past(start));

   // R8: functional reset seen for at least two clocks before completion
   a_r8_hold_min: assert property (@(posedge fn_clk) disable iff (!fn_rst_n)
      $rose(done_f) |-> ($past(fn_srst) && $past(fn_srst, 2)));
endmodule

// File: rtl/posted_wr_tracker.sv
module posted_wr_tracker import wpt_pkg::*; #(
   parameter int            DW        = 32,
   parameter int            STAGES    = 2,
   parameter int            SRST_HOLD = 2,
   parameter logic [DW-1:0] RST_VAL   = '0
) (
   input  logic               bus_clk,
   input  logic               bus_rst_n,
   input  logic               fn_clk,
   input  logic               fn_rst_n,
   input  logic               bus_wr,
   input  logic [AW-1:0]      bus_addr,
   input  logic [DW-1:0]      bus_wdata,
   output logic [DW-1:0]      bus_rdata,
   output logic               bus_ready,
   output logic [NREG*DW-1:0] fn_regs,
   output logic               fn_soft_rst
);
   if (DW < NREG) begin : g_bad_dw
      $error("posted_wr_tracker: DW must hold one pending bit per register");
   end

   logic            wr_ok;
   logic            ifc_wr;
   logic            sr_start;
   logic            sr_busy;
   logic            posted_q;
   logic [NREG-1:0] hit;
   logic [NREG-1:0] pend;
   logic [NREG-1:0] req_tgl;
   logic [NREG-1:0] ack_tgl;
   logic [DW-1:0]   hold   [NREG];
   logic [DW-1:0]   chan_rd[NREG];

   assign wr_ok     = bus_wr & bus_ready;
   assign bus_ready = posted_q | ~(|pend);
   assign ifc_wr    = wr_ok & (bus_addr == OFF_IFC) & ~sr_busy;
   assign sr_start  = ifc_wr & bus_wdata[IFC_SRST_BIT];

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n)    posted_q <= 1'b1;
      else if (sr_start) posted_q <= 1'b1;
      else if (ifc_wr)   posted_q <= bus_wdata[IFC_POST_BIT];
   end

   wpt_srst_ctl #(.STAGES(STAGES), .HOLD(SRST_HOLD)) u_srst (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
      .fn_clk(fn_clk), .fn_rst_n(fn_rst_n),
      .start(sr_start), .busy(sr_busy), .fn_srst(fn_soft_rst));

   for (genvar i = 0; i < NREG; i++) begin : g_chan
      assign hit[i] = (bus_addr == REG_OFF[i]);

      wpt_bus_chan #(.DW(DW), .STAGES(STAGES), .RST_VAL(RST_VAL)) u_bus (
         .clk(bus_clk), .rst_n(bus_rst_n),
         .wr_hit(wr_ok & hit[i]), .wdata(bus_wdata),
         .clr(sr_start), .sr_busy(sr_busy),
         .ack_tgl_f(ack_tgl[i]), .req_tgl(req_tgl[i]),
         .hold_q(hold[i]), .rdata(chan_rd[i]), .pend(pend[i]));

      wpt_fn_chan #(.DW(DW), .STAGES(STAGES), .RST_VAL(RST_VAL)) u_fn (
         .clk(fn_clk), .rst_n(fn_rst_n), .srst(fn_soft_rst),
         .req_tgl_b(req_tgl[i]), .hold_b(hold[i]),
         .ack_tgl(ack_tgl[i]), .q(fn_regs[i*DW +: DW]));
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == OFF_SYSSTAT) bus_rdata[0] = ~sr_busy;
      if (bus_addr == OFF_WPEND && posted_q) bus_rdata[NREG-1:0] = pend;
      if (bus_addr == OFF_IFC) bus_rdata[IFC_POST_BIT] = posted_q;
      for (int i = 0; i < NREG; i++) begin
         if (hit[i]) bus_rdata = chan_rd[i];
      end
   end

   // R6: an accepted non-posted write stalls the bus on the next cycle
   a_r6_nonposted_stall: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (!posted_q && wr_ok && (|hit) && !sr_busy) |=> !bus_ready);
endmodule

// File: tb/posted_wr_tracker_tb_top.sv
module posted_wr_tracker_tb_top;
   localparam int BUS_PERIOD = 10;
   localparam int FN_PERIOD  = 26;
   localparam int DW = 32;
   localparam int N  = 10;

   // {offset, data}; index = pending bit
   localparam logic [39:0] VEC [N] = '{
      {8'h24, 32'h0000_0011}, {8'h28, 32'h1234_5678}, {8'h2C, 32'hFFFF_0000},
      {8'h30, 32'h0000_0001}, {8'h38, 32'hDEAD_BEEF}, {8'h48, 32'h0F0F_0F0F},
      {8'h4C, 32'h8000_0000}, {8'h50, 32'h0000_ABCD}, {8'h54, 32'h5555_5555},
      {8'h58, 32'hA5A5_A5A5}};

   logic bus_clk = 0, fn_clk = 0;
   logic bus_rst_n = 0, fn_rst_n = 0;
   logic bus_wr = 0;
   logic [7:0] bus_addr = 0;
   logic [DW-1:0] bus_wdata = 0;
   logic [DW-1:0] bus_rdata;
   logic bus_ready;
   logic [N*DW-1:0] fn_regs;
   logic fn_soft_rst;

   int checks = 0, errors = 0, sr_cycles = 0;
   bit done = 0;

   always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
   always #(FN_PERIOD/2)  fn_clk  = ~fn_clk;
   always @(posedge fn_clk) if (fn_soft_rst) sr_cycles++;

   posted_wr_tracker dut_i (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .fn_clk(fn_clk), .fn_rst_n(fn_rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .fn_regs(fn_regs), .fn_soft_rst(fn_soft_rst));

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(logic [7:0] a, output logic [DW-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wr(logic [7:0] a, logic [DW-1:0] d);
      @(negedge bus_clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      for (int k = 0; k < 1000 && !bus_ready; k++) @(negedge bus_clk);
      @(negedge bus_clk);
      bus_wr = 0;
   endtask

   task automatic wait_idle();
      logic [DW-1:0] v;
      for (int k = 0; k < 300; k++) begin
         rd(8'h34, v);
         if (v == 0) return;
         @(negedge bus_clk);
      end
   endtask

   task automatic wait_srst_done();
      logic [DW-1:0] v;
      for (int k = 0; k < 500; k++) begin
         rd(8'h14, v);
         if (v[0]) return;
         @(negedge bus_clk);
      end
   endtask

   initial begin
      #(BUS_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(negedge bus_clk);
      bus_rst_n = 1; fn_rst_n = 1;
      repeat (2) @(negedge bus_clk);

      // R1 reset state
      rd(8'h40, v); chk("R1 ifc", v, 32'h4);
      rd(8'h34, v); chk("R1 wpend", v, 0);
      rd(8'h14, v); chk("R1 sysstat", v, 32'h1);
      chk("R1 fn_regs", fn_regs[DW-1:0] | fn_regs[9*DW +: DW], 0);

      // R2 / R4 table walk
      for (int i = 0; i < N; i++) begin
         wr(VEC[i][39:32], VEC[i][31:0]);
         chk("R2 ready posted", {31'b0, bus_ready}, 1);
         rd(8'h34, v); chk("R2 pend bit", v, 32'(1) << i);
         rd(VEC[i][39:32], v); chk("R4 stale read", v, 0);
         wait_idle();
         chk("R2 applied", fn_regs[i*DW +: DW], VEC[i][31:0]);
         rd(VEC[i][39:32], v); chk("R4 new read", v, VEC[i][31:0]);
      end

      // R3 collision
      wr(8'h24, 32'hAAAA_0001);
      wr(8'h24, 32'hBBBB_0002);
      wait_idle();
      chk("R3 dropped fn", fn_regs[0 +: DW], 32'hAAAA_0001);
      rd(8'h24, v); chk("R3 dropped read", v, 32'hAAAA_0001);

      // R5 independent bits
      wr(8'h2C, 32'h0000_2C2C);
      wr(8'h38, 32'h0000_3838);
      rd(8'h34, v); chk("R5 both pending", v & 32'h14, 32'h14);
      wait_idle();
      chk("R5 load", fn_regs[2*DW +: DW], 32'h0000_2C2C);
      chk("R5 match", fn_regs[4*DW +: DW], 32'h0000_3838);

      // R6 non-posted
      wr(8'h40, 32'h0);
      rd(8'h40, v); chk("R6 ifc", v, 0);
      wr(8'h28, 32'h0000_7777);
      chk("R6 stall", {31'b0, bus_ready}, 0);
      rd(8'h34, v); chk("R6 wpend zero", v, 0);
      for (int k = 0; k < 300 && !bus_ready; k++) @(negedge bus_clk);
      chk("R6 ready back", {31'b0, bus_ready}, 1);
      chk("R6 applied", fn_regs[1*DW +: DW], 32'h0000_7777);
      wr(8'h40, 32'h4);

      // R9 unmapped and status writes
      rd(8'h00, v); chk("R9 unmapped", v, 0);
      rd(8'h5C, v); chk("R9 unmapped hi", v, 0);
      wr(8'h34, 32'hFFFF_FFFF);
      rd(8'h34, v); chk("R9 wpend write", v, 0);
      wr(8'h14, 32'h0);
      rd(8'h14, v); chk("R9 sysstat write", v, 32'h1);

      // R7 / R8 soft reset
      wr(8'h40, 32'h0);
      sr_cycles = 0;
      wr(8'h40, 32'h6);
      rd(8'h14, v); chk("R7 busy", v, 0);
      wr(8'h2C, 32'h0000_9999);
      wait_srst_done();
      rd(8'h14, v); chk("R7 done", v, 32'h1);
      repeat (20) @(negedge bus_clk);
      chk("R7 fn cleared", (fn_regs == '0) ? 32'h1 : 32'h0, 32'h1);
      rd(8'h34, v); chk("R7 wpend", v, 0);
      rd(8'h40, v); chk("R7 posted on", v, 32'h4);
      rd(8'h2C, v); chk("R7 dropped write", v, 0);
      chk("R8 hold cycles", (sr_cycles >= 2) ? 32'h1 : 32'h0, 32'h1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule